// File: doc/BRIEF.md
# Three-Lane 7:1 Display Serializer

This block takes a 21-bit pixel word and sends it out serially once per pixel clock. Bits 0 to 17 carry colour. Bits 18, 19 and 20 carry the line-sync, frame-sync and data-ready controls. The word is split across three serial data lanes of seven bits each. A fourth lane sends a forwarded copy of the pixel clock, aligned to the data lanes. A bit clock at seven times the pixel rate drives all serial logic. A one-cycle phase strobe from the clock source marks the bit-clock edge at which a new pixel period begins.

The input word is captured on the falling pixel-clock edge. At the start of each pixel period the whole captured word moves into per-lane shadow registers in a single bit-clock cycle. Each lane then shifts its seven bits out in slots 0 to 6, least-significant bit first.

An active-low power-down input disables all four lanes. A small state machine with three states controls the output enables:
- `PW_OFF`: powered down.
- `PW_LOCK`: waiting for the external clock to settle.
- `PW_RUN`: driving.

It has four transitions:
- OFF→LOCK, when power-down is released.
- LOCK→RUN, after `LOCK_PIX` pixel boundaries.
- LOCK→OFF, when power-down is asserted.
- RUN→OFF, when power-down is asserted.

Top module: `dser_tx`

## Requirements
- R1: `pix_word` is captured on the falling edge of `pix_clk`. The word captured most recently before a pixel boundary is the one sent during the pixel period that follows that boundary.
- R2: Lane mapping. Lane 0 (`lane_dat[0]`) sends word bits 0..6, lane 1 sends bits 7..13 and lane 2 sends bits 14..20. Bit `l*7+s` appears in slot `s`, so bit 0 of each group goes first.
- R3: All three lanes reload together at the slot-0 boundary. Within one pixel period, a lane never mixes bits of two words.
- R4: While enabled, `clk_lane` is high in slots 0, 1, 5 and 6 and low in slots 2, 3 and 4. This is the 7-bit pattern 1100011 with slot 0 as the low bit.
- R5: When `pix_phase` is high at a `bit_clk` rising edge, the next slot is slot 0. Otherwise slots advance 0..6 and wrap to 0.
- R6: When `pd_n` is low at a `bit_clk` edge, all four bits of `lane_oe` are 0 from that edge on. While the enables are 0, `lane_dat` and `clk_lane` are 0.
- R7: After `pd_n` returns high, `lane_oe` stays 0 until `LOCK_PIX` pixel boundaries have passed. It then becomes all ones at a slot-0 boundary.
- R8: While `rst_n` is low, `lane_oe`, `lane_dat` and `clk_lane` are 0, independent of the clocks. Reset leaves the block powered down.
- R9: All four bits of `lane_oe` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate |
| pix_clk | input | 1 | Pixel clock; the word is captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| pix_phase | input | 1 | High for one bit clock before slot 0 of a pixel period |
| pix_word | input | 21 | Pixel word: colour bits 0..17, line sync 18, frame sync 19, data ready 20 |
| lane_dat | output | 3 | Serial data lanes |
| clk_lane | output | 1 | Forwarded clock lane |
| lane_oe | output | 4 | Output enables; bits 0..2 for the data lanes, bit 3 for the clock lane |

## Verification
Words are sent in several patterns, and each pattern tells apart a different fault:
- Alternating bit patterns (0x155555, 0x0AAAAA) separate slot order from lane order.
- Words with exactly one lane group set (0x7F, 0x3F80, 0x1FC000) expose a swapped lane.
- A single bit in slot 6 (0x40) exposes a reversed bit order.
- All ones and mixed words cover general data paths.

Power-down is dropped in the middle of a pixel period to show that the enables and data fall at the next bit-clock edge. It is then released to show that the lock count ends on a pixel boundary. A phase strobe sent off-schedule in slot 2 shows that the clock-lane pattern restarts at slot 0. An asynchronous reset in mid-run shows that all outputs fall without a clock edge.

// File: rtl/dser_pkg.sv
package dser_pkg;

    localparam int DATA_LANES  = 3;
    localparam int LANE_SLOTS  = 7;
    localparam int LOCK_PIXELS = 1024;
    // forwarded clock shape, slot 0 in bit 0: high in slots 0,1,5,6
    localparam logic [LANE_SLOTS-1:0] FWD_CLK_PATTERN = 7'b1100011;

    typedef enum logic [1:0] {
        PW_OFF  = 2'd0,
        PW_LOCK = 2'd1,
        PW_RUN  = 2'd2
    } pwr_state_t;

endpackage

// File: rtl/dser_capture.sv
module dser_capture #(
    parameter int WORD_W = 21
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_q
);

    // word is sampled on the falling pixel-clock edge
    always_ff @(negedge pix_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/dser_slot_seq.sv
module dser_slot_seq #(
    parameter  int SLOTS = 7,
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase,
    output logic [SW-1:0] nxt_slot,
    output logic          wrap
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic [SW-1:0] slot_q;

    always_comb begin
        if (phase || (slot_q == LAST_SLOT)) begin
            nxt_slot = '0;
        end else begin
            nxt_slot = slot_q + SW'(1);
        end
        wrap = (nxt_slot == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= LAST_SLOT;
        end else begin
            slot_q <= nxt_slot;
        end
    end

endmodule

// File: rtl/dser_lane.sv
module dser_lane #(
    parameter  int SLOTS = 7,
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [SW-1:0]    nxt_slot,
    input  logic [SLOTS-1:0] load_bits,
    output logic             bit_q
);

    logic [SLOTS-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            bit_q    <= 1'b0;
        end else if (wrap) begin
            shadow_q <= load_bits;
            bit_q    <= load_bits[0];
        end else begin
            bit_q    <= shadow_q[nxt_slot];
        end
    end

endmodule

// File: rtl/dser_pwr_fsm.sv
module dser_pwr_fsm
    import dser_pkg::*;
#(
    parameter  int LOCK_PIX = 1024,
    localparam int CW       = $clog2(LOCK_PIX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic wrap,
    output logic drive_en
);

    localparam logic [CW-1:0] LAST_CNT = CW'(LOCK_PIX - 1);

    pwr_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PW_OFF: begin
                cnt_d = '0;
                if (pd_n) begin
                    state_d = PW_LOCK;
                end
            end
            PW_LOCK: begin
                if (!pd_n) begin
                    state_d = PW_OFF;
                    cnt_d   = '0;
                end else if (wrap) begin
                    if (cnt_q == LAST_CNT) begin
                        state_d = PW_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            PW_RUN: begin
                if (!pd_n) begin
                    state_d = PW_OFF;
                end
            end
            default: begin
                state_d = PW_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        drive_en = (state_q == PW_RUN);
    end

endmodule

// File: rtl/dser_tx.sv
module dser_tx
    import dser_pkg::*;
#(
    parameter  int                 LANES    = DATA_LANES,
    parameter  int                 SLOTS    = LANE_SLOTS,
    parameter  int                 LOCK_PIX = LOCK_PIXELS,
    parameter  logic [SLOTS-1:0]   CLK_PAT  = FWD_CLK_PATTERN,
    localparam int                 WORD_W   = LANES * SLOTS,
    localparam int                 SW       = $clog2(SLOTS)
) (
    input  logic              bit_clk,
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              pix_phase,
    input  logic [WORD_W-1:0] pix_word,
    output logic [LANES-1:0]  lane_dat,
    output logic              clk_lane,
    output logic [LANES:0]    lane_oe
);

    logic [WORD_W-1:0] cap_word;
    logic [SW-1:0]     nxt_slot;
    logic              wrap;
    logic              drive_en;
    logic [LANES:0]    lane_bit;

    dser_capture #(.WORD_W(WORD_W)) u_cap (
        .pix_clk (pix_clk),
        .rst_n   (rst_n),
        .word_in (pix_word),
        .word_q  (cap_word)
    );

    dser_slot_seq #(.SLOTS(SLOTS)) u_seq (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .phase    (pix_phase),
        .nxt_slot (nxt_slot),
        .wrap     (wrap)
    );

    dser_pwr_fsm #(.LOCK_PIX(LOCK_PIX)) u_pwr (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .pd_n     (pd_n),
        .wrap     (wrap),
        .drive_en (drive_en)
    );

    for (genvar l = 0; l <= LANES; l++) begin : g_lane
        if (l < LANES) begin : g_data
            dser_lane #(.SLOTS(SLOTS)) u_lane (
                .clk       (bit_clk),
                .rst_n     (rst_n),
                .wrap      (wrap),
                .nxt_slot  (nxt_slot),
                .load_bits (cap_word[l*SLOTS +: SLOTS]),
                .bit_q     (lane_bit[l])
            );
        end else begin : g_clk
            dser_lane #(.SLOTS(SLOTS)) u_lane (
                .clk       (bit_clk),
                .rst_n     (rst_n),
                .wrap      (wrap),
                .nxt_slot  (nxt_slot),
                .load_bits (CLK_PAT),
                .bit_q     (lane_bit[l])
            );
        end
    end

    always_comb begin
        lane_dat = lane_bit[LANES-1:0] & {LANES{drive_en}};
        clk_lane = lane_bit[LANES] & drive_en;
        lane_oe  = {(LANES + 1){drive_en}};
    end

endmodule

// File: rtl/dser_tx_chk.sv
module dser_tx_chk #(
    parameter  int LANES = 3,
    parameter  int SLOTS = 7,
    localparam int SW    = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_n,
    input logic             pix_phase,
    input logic [LANES-1:0] lane_dat,
    input logic             clk_lane,
    input logic [LANES:0]   lane_oe
);

    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    // independent slot tracker for the checks
    logic [SW-1:0] ref_slot;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_slot <= LAST;
        end else if (pix_phase || ref_slot == LAST) begin
            ref_slot <= '0;
        end else begin
            ref_slot <= ref_slot + SW'(1);
        end
    end

    // R6
    pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (lane_oe == '0 && lane_dat == '0 && !clk_lane));

    // R7
    oe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_oe[0]) |-> (ref_slot == '0));

    // R4
    clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe[LANES] && ref_slot >= SW'(2) && ref_slot <= SW'(4)) |-> !clk_lane);

    // R4
    clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe[LANES] && (ref_slot < SW'(2) || ref_slot > SW'(4))) |-> clk_lane);

    // R9
    oe_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe == '0) || (lane_oe == '1));

endmodule

bind dser_tx dser_tx_chk #(.LANES(LANES), .SLOTS(SLOTS)) u_chk (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .pix_phase (pix_phase),
    .lane_dat  (lane_dat),
    .clk_lane  (clk_lane),
    .lane_oe   (lane_oe)
);

// File: tb/dser_tx_tb_top.sv
module dser_tx_tb_top;

    localparam int CLK_T = 10;
    localparam int LOCK  = 3;
    localparam int NV    = 13;
    localparam logic [6:0] PAT = 7'b1100011;

    logic        bit_clk = 1'b0;
    logic        pix_clk = 1'b1;
    logic        rst_n   = 1'b0;
    logic        pd_n    = 1'b0;
    logic        pix_phase = 1'b0;
    logic [20:0] pix_word = '0;
    logic [2:0]  lane_dat;
    logic        clk_lane;
    logic [3:0]  lane_oe;

    int n_chk  = 0;
    int n_fail = 0;

    dser_tx #(.LOCK_PIX(LOCK)) dut_i (
        .bit_clk   (bit_clk),
        .pix_clk   (pix_clk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .pix_phase (pix_phase),
        .pix_word  (pix_word),
        .lane_dat  (lane_dat),
        .clk_lane  (clk_lane),
        .lane_oe   (lane_oe)
    );

    always #(CLK_T/2) bit_clk = ~bit_clk;

    // {pd_n applied in slot 2, expected enable per slot (bit = slot), word}
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 7'h00, 21'h155555},
        {1'b1, 7'h00, 21'h0AAAAA},
        {1'b1, 7'h00, 21'h00007F},
        {1'b1, 7'h7F, 21'h003F80},
        {1'b1, 7'h7F, 21'h1FC000},
        {1'b0, 7'h07, 21'h12D687},
        {1'b0, 7'h00, 21'h000001},
        {1'b1, 7'h00, 21'h100000},
        {1'b1, 7'h00, 21'h0ABCDE},
        {1'b1, 7'h00, 21'h1FFFFF},
        {1'b1, 7'h7F, 21'h000040},
        {1'b1, 7'h7F, 21'h0E38E3},
        {1'b1, 7'h7F, 21'h000000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [20:0] prev_w = '0;

    task automatic run_pixel(input logic [20:0] w, input logic pd, input logic [6:0] mask);
        logic [20:0] obs_d, exp_d;
        logic [6:0]  obs_c, exp_c, obs_e;
        for (int i = 0; i < 7; i++) begin
            @(negedge bit_clk);
            for (int l = 0; l < 3; l++) begin
                obs_d[l*7+i] = lane_dat[l];
                exp_d[l*7+i] = prev_w[l*7+i] & mask[i];
            end
            obs_c[i] = clk_lane;
            exp_c[i] = PAT[i] & mask[i];
            obs_e[i] = (lane_oe == 4'hF) ? 1'b1 : ((lane_oe == 4'h0) ? 1'b0 : ~mask[i]);
            pix_phase = (i == 6);
            if (i == 0) begin
                pix_clk  = 1'b1;
                pix_word = w;
            end
            if (i == 2) pd_n = pd;
            if (i == 3) pix_clk = 1'b0;
        end
        // R1 R2 R3: previous word, lane groups LSB first, masked by enable
        check("R1/R2/R3 data", {11'd0, obs_d}, {11'd0, exp_d});
        // R4: clock lane pattern
        check("R4 clk", {25'd0, obs_c}, {25'd0, exp_c});
        // R6 R7 R9: enables per slot
        check("R6/R7/R9 oe", {25'd0, obs_e}, {25'd0, mask});
        prev_w = w;
    endtask

    initial begin
        #(CLK_T * 20000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge bit_clk);
        // R8: reset state
        check("R8 reset", {25'd0, lane_oe, lane_dat, clk_lane}, 32'd0);
        rst_n     = 1'b1;
        pd_n      = 1'b1;
        pix_phase = 1'b1;

        for (int p = 0; p < NV; p++) begin
            run_pixel(VEC[p][20:0], VEC[p][28], VEC[p][27:21]);
        end

        // R5: phase strobe in slot 2 restarts slot count
        @(negedge bit_clk); pix_phase = 1'b0;   // slot 0
        @(negedge bit_clk);                      // slot 1
        @(negedge bit_clk); pix_phase = 1'b1;   // slot 2
        @(negedge bit_clk); pix_phase = 1'b0;
        check("R5 slot0 clk", {31'd0, clk_lane}, 32'd1);
        @(negedge bit_clk);
        check("R5 slot1 clk", {31'd0, clk_lane}, 32'd1);
        @(negedge bit_clk);
        check("R5 slot2 clk", {31'd0, clk_lane}, 32'd0);

        // R8: asynchronous reset mid-run
        @(negedge bit_clk);
        check("R8 oe before reset", {28'd0, lane_oe}, 32'hF);
        rst_n = 1'b0;
        #1;
        check("R8 async reset", {25'd0, lane_oe, lane_dat, clk_lane}, 32'd0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule